// File: doc/BRIEF.md
# Encoder Input Glitch Filter

This block cleans up the three signals that come from an incremental encoder: two quadrature phases and an index pulse. Each raw pin first goes through a chain of synchronising flops. It then goes through a stability qualifier whose length can be programmed. The cleaned levels feed a quadrature decoder, which is outside this block.

The configuration has two parts: a filter-on bit and a 21-bit length field. A new level is accepted only after it has been seen for the programmed length plus two clock periods. With the filter off, the synchronised levels go straight through to the output register. A `run` input shows that the parent peripheral is active. While it is high, configuration writes are dropped, so the qualifier never sees its settings change in the middle of a measurement. The active settings are visible on two read-back outputs.

Top module: `enc_glitch_filter`

## Requirements
- R1: While reset is asserted and after it is released, all three cleaned outputs are low, `cur_flt_on` is 0 and `cur_len` is 0.
- R2: With `cur_flt_on` = 0, each cleaned output equals its raw input as sampled three rising edges earlier: two synchroniser stages plus the output register.
- R3: With `cur_flt_on` = 1 and length L, a raw level change held steady reaches the output at the (L+4)th rising edge after it is applied. It is absent after L+3 edges.
- R4: With the filter on, a raw excursion lasting only L+1 clock cycles never reaches the output.
- R5: With the filter on, a return of the synchronised input to the current output level before the threshold is reached restarts that channel's stability count. Repeated short excursions, each one cycle shy of the threshold, leave the output unchanged.
- R6: The three channels are qualified independently. A change on one input neither delays nor advances the others.
- R7: When `run` = 0, a cycle with `cfg_we` = 1 loads `cfg_flt_on` and `cfg_len`. The new values appear on `cur_flt_on` and `cur_len` after that rising edge.
- R8: When `run` = 1, `cfg_we` has no effect. `cur_flt_on`, `cur_len` and the filtering behaviour stay as they were.
- R9: The length field holds every value from 0 to 0x1FFFFF; writing 0x1FFFFF reads back as 0x1FFFFF.
- R10: With length 0 the threshold is two cycles: a one-cycle excursion is removed and a two-cycle one passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Parent peripheral active; locks the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flt_on | input | 1 | Filter enable to load |
| cfg_len | input | CNT_W | Filter length to load |
| in_a | input | 1 | Raw phase A |
| in_b | input | 1 | Raw phase B |
| in_z | input | 1 | Raw index |
| out_a | output | 1 | Cleaned phase A |
| out_b | output | 1 | Cleaned phase B |
| out_z | output | 1 | Cleaned index |
| cur_flt_on | output | 1 | Active filter enable |
| cur_len | output | CNT_W | Active filter length |

## Verification
The bench builds the block with its default 21-bit length field and two synchroniser stages. The whole field width can therefore be written and read back, up to 0x1FFFFF. All timing scenarios use lengths from 0 to 5. This keeps every qualification window a few cycles long, so random input toggling lands many excursions both just below and just at the threshold, on all three channels at once. It also produces configuration writes with the lock both asserted and released.

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter #(
  parameter int CNT_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic             cfg_flt_on,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_z,
  output logic             out_a,
  output logic             out_b,
  output logic             out_z,
  output logic             cur_flt_on,
  output logic [CNT_W-1:0] cur_len
);
  localparam int NCH   = 3;
  localparam int RUN_W = CNT_W + 1;

  logic             flt_q;
  logic [CNT_W-1:0] len_q;
  logic [NCH-1:0]   raw;
  logic [NCH-1:0]   synced;
  logic [NCH-1:0]   clean;
  logic [NCH-1:0]   sync_pipe [SYNC_STAGES];
  logic [RUN_W-1:0] limit;

  assign raw    = {in_z, in_b, in_a};
  assign synced = sync_pipe[SYNC_STAGES-1];
  assign limit  = {1'b0, len_q} + RUN_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= 1'b0;
      len_q <= '0;
    end else if (cfg_we && !run) begin
      flt_q <= cfg_flt_on;
      len_q <= cfg_len;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_pipe[i] <= '0;
    end else begin
      sync_pipe[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_pipe[i] <= sync_pipe[i-1];
    end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [RUN_W-1:0] stab_cnt;
    logic             lvl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        stab_cnt <= '0;
        lvl      <= 1'b0;
      end else if (!flt_q) begin
        stab_cnt <= '0;
        lvl      <= synced[ch];
      end else if (synced[ch] == lvl) begin
        stab_cnt <= '0;
      end else if (stab_cnt == limit) begin
        stab_cnt <= '0;
        lvl      <= synced[ch];
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end

    assign clean[ch] = lvl;
  end

  assign out_a      = clean[0];
  assign out_b      = clean[1];
  assign out_z      = clean[2];
  assign cur_flt_on = flt_q;
  assign cur_len    = len_q;
endmodule

// File: rtl/enc_glitch_filter_chk.sv
module enc_glitch_filter_chk #(
  parameter int NCH   = 3,
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             flt_on,
  input logic [CNT_W-1:0] len,
  input logic [NCH-1:0]   synced,
  input logic [NCH-1:0]   clean
);
  // R8
  cfg_len_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(len));

  // R8
  cfg_on_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(flt_on));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_prop
    // R3
    min_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_on && $past(flt_on) && clean[ch] != $past(clean[ch]))
        |-> ($past(synced[ch] != clean[ch]) && $past(synced[ch] != clean[ch], 2)));

    // R5
    match_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_on && synced[ch] == clean[ch]) |=> $stable(clean[ch]));
  end
endmodule

bind enc_glitch_filter enc_glitch_filter_chk #(.NCH(3), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run),
  .flt_on (cur_flt_on),
  .len    (cur_len),
  .synced (synced),
  .clean  (clean)
);

// File: tb/sim_enc_glitch_filter.sv
module sim_enc_glitch_filter;
  localparam int CNT_W = 21;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_flt_on = 1'b0;
  logic [CNT_W-1:0] cfg_len = '0;
  logic             in_a = 1'b0, in_b = 1'b0, in_z = 1'b0;
  logic             out_a, out_b, out_z, cur_flt_on;
  logic [CNT_W-1:0] cur_len;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  enc_glitch_filter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_flt_on(cfg_flt_on), .cfg_len(cfg_len),
    .in_a(in_a), .in_b(in_b), .in_z(in_z),
    .out_a(out_a), .out_b(out_b), .out_z(out_z),
    .cur_flt_on(cur_flt_on), .cur_len(cur_len)
  );

  // Requirement model: two-edge synchroniser delay, then L+2 stable samples.
  logic [2:0] m_p1, m_p2, m_out;
  int         m_cnt [3];
  logic       m_flt;
  int         m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= '0; m_p2 <= '0; m_out <= '0; m_flt <= 1'b0; m_len <= 0;
      for (int i = 0; i < 3; i++) m_cnt[i] <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (!m_flt) begin
          m_out[i] <= m_p2[i]; m_cnt[i] <= 0;
        end else if (m_p2[i] == m_out[i]) begin
          m_cnt[i] <= 0;
        end else if (m_cnt[i] + 1 == m_len + 2) begin
          m_out[i] <= m_p2[i]; m_cnt[i] <= 0;
        end else begin
          m_cnt[i] <= m_cnt[i] + 1;
        end
      end
      m_p2 <= m_p1;
      m_p1 <= {in_z, in_b, in_a};
      if (cfg_we && !run) begin
        m_flt <= cfg_flt_on; m_len <= int'(cfg_len);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic on, input int len);
    cfg_flt_on = on; cfg_len = CNT_W'(len); cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    chk({out_z, out_b, out_a} == 3'b000, "R1 outputs in reset", {out_z, out_b, out_a}, 0);
    tick(2);
    rst_n = 1'b1;
    tick();
    chk({out_z, out_b, out_a} == 3'b000, "R1 outputs after reset", {out_z, out_b, out_a}, 0);
    chk(cur_flt_on == 1'b0 && cur_len == '0, "R1 config after reset", {cur_flt_on, cur_len}, 0);

    // R2 bypass latency: three edges
    in_b = 1'b1;
    tick(2);
    chk(out_b == 1'b0, "R2 bypass not before 3 edges", out_b, 0);
    tick();
    chk(out_b == 1'b1, "R2 bypass after 3 edges", out_b, 1);
    in_b = 1'b0;
    tick(3);
    chk(out_b == 1'b0, "R2 bypass falling", out_b, 0);

    // R7 load while idle
    write_cfg(1'b1, 3);
    chk(cur_flt_on == 1'b1 && cur_len == 3, "R7 config loaded", {cur_flt_on, cur_len}, {1'b1, 21'd3});

    // R4 pulse of L+1 = 4 cycles dropped
    in_a = 1'b1; tick(4); in_a = 1'b0;
    tick(10);
    chk(out_a == 1'b0, "R4 short pulse removed", out_a, 0);

    // R3 level held: visible at edge L+4 = 7
    in_a = 1'b1;
    tick(6);
    chk(out_a == 1'b0, "R3 not yet at L+3 edges", out_a, 0);
    tick();
    chk(out_a == 1'b1, "R3 accepted at L+4 edges", out_a, 1);

    // R6 independence: B held while Z glitches
    in_b = 1'b1; in_z = 1'b1; tick(2); in_z = 1'b0;
    tick(5);
    chk(out_b == 1'b1, "R6 B accepted alongside Z glitch", out_b, 1);
    chk(out_z == 1'b0 && out_a == 1'b1, "R6 Z glitch removed, A kept", {out_z, out_a}, 1);

    // R5 bounces restart the count
    for (int k = 0; k < 4; k++) begin
      in_a = 1'b0; tick(4); in_a = 1'b1; tick(1);
    end
    tick(8);
    chk(out_a == 1'b1, "R5 repeated near-threshold dips ignored", out_a, 1);

    // R8 write while running is ignored
    run = 1'b1;
    write_cfg(1'b0, 9);
    chk(cur_flt_on == 1'b1 && cur_len == 3, "R8 config held while running", {cur_flt_on, cur_len}, {1'b1, 21'd3});
    in_b = 1'b0; tick(4); in_b = 1'b1;
    tick(10);
    chk(out_b == 1'b1, "R8 filtering unchanged while running", out_b, 1);
    run = 1'b0;

    // R9 full-range field
    write_cfg(1'b1, 21'h1FFFFF);
    chk(cur_len == 21'h1FFFFF, "R9 max length stored", cur_len, 21'h1FFFFF);

    // R10 length zero: two-cycle threshold
    write_cfg(1'b1, 0);
    in_z = 1'b1; tick(1); in_z = 1'b0;
    tick(8);
    chk(out_z == 1'b0, "R10 one-cycle pulse removed", out_z, 0);
    in_z = 1'b1; tick(2); in_z = 1'b0;
    tick(2);
    chk(out_z == 1'b1, "R10 two-cycle pulse passes", out_z, 1);
    tick(6);
    chk(out_z == 1'b0, "R10 returns low", out_z, 0);

    // Random phase against the requirement model (R2 R3 R4 R6 R8)
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(5) == 0) in_a = ~in_a;
      if ($urandom_range(5) == 0) in_b = ~in_b;
      if ($urandom_range(4) == 0) in_z = ~in_z;
      if ($urandom_range(39) == 0) run = ~run;
      cfg_we = ($urandom_range(49) == 0);
      cfg_flt_on = ($urandom_range(3) != 0);
      cfg_len = CNT_W'($urandom_range(5));
      tick();
      chk({out_z, out_b, out_a} == m_out, "R6 random outputs (R2 R3 R4)", {out_z, out_b, out_a}, m_out);
      chk(cur_flt_on == m_flt && int'(cur_len) == m_len, "R8 random config (R7)",
          {cur_flt_on, cur_len}, {m_flt, CNT_W'(m_len)});
    end
    cfg_we = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule